// File: doc/BRIEF.md
# Capture Input Glitch Filter

This block cleans up one raw timer capture input before it reaches edge detection. The input first passes through a resynchronising flop chain into the clock domain. It is then sampled at a rate chosen by a 4-bit filter code. A new level reaches the filtered output only after that level has been seen on N samples in a row. Glitches and bounce shorter than the confirmation window never reach the output.

The sampling rate comes from one of two places. The first is the internal clock itself, where every cycle is a sample. The second is a sampling-clock enable pulse, either used directly or divided down by 2, 4, 8, 16 or 32. The same code sets the confirmation count N. There is no streaming data path: every pin is a plain control or level signal, with no valid/ready handshake and no back-pressure.

Top module: `capture_glitch_filter`

## Requirements
- R1: After reset the filtered output is 0, and the confirmation and divider counters are cleared.
- R2: The raw input passes through two synchroniser flops. With code 0 and the sample enable held high, a raw change appears at the output on the 3rd rising edge after it is applied.
- R3: Code 0 applies no filtering. The output takes the synchronised level on every cycle where the sample enable is high, and holds while the enable is low.
- R4: Codes 1, 2 and 3 sample on every clock cycle whatever the sample enable does, and need 2, 4 and 8 consecutive differing samples respectively. The latency is therefore N+2 edges.
- R5: Codes 4 to 15 sample once every D sample-enable pulses. D is 2 for codes 4-5, 4 for codes 6-7, 8 for codes 8-9, 16 for codes 10-12 and 32 for codes 13-15.
- R6: N is 6 for codes 4, 6 and 8. N is 8 for codes 5, 7, 9, 12 and 15. N is 5 for codes 10 and 13, and 6 for codes 11 and 14. The output changes only after N consecutive samples differ from it, so a pulse covering fewer than N samples is rejected.
- R7: A sample equal to the current output clears the confirmation count, so an interrupted run must start again.
- R8: On any change of the filter code, the divider and the confirmation count are cleared in the first cycle of the new code, no sample is taken in that cycle, and the output keeps its value.
- R9: With a divided code (4-15) and the sample enable low, the output never changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sampling-clock enable pulse, one clock wide per sampling tick |
| raw_in | input | 1 | Unsynchronised capture input |
| flt_code | input | 4 | Filter code selecting sampling divider and N |
| flt_out | output | 1 | Filtered, synchronised level |

## Verification
On every cycle, the assertions check the following. The output never moves in the cycle a code change is seen, nor while a divided code lacks its enable. Every output change takes the synchronised level. The confirmation count stays below the code's N. What only the bench scenarios can show is the full table: the exact or bounded latency for each of the 16 codes, the rejection of pulses just short of N samples, the restart after an interrupted run, and the cleared count after a code switch.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
  localparam int CNT_W = 4;
  localparam int DIVL_W = 3;

  typedef struct packed {
    logic              on_clk;   // sample every clock, ignore enable
    logic [DIVL_W-1:0] div_log2; // divider = 2**div_log2 enable pulses
    logic [CNT_W-1:0]  need;     // consecutive samples to confirm
  } cfg_t;

  function automatic cfg_t decode(input logic [3:0] code);
    cfg_t c;
    c = '{on_clk: 1'b0, div_log2: '0, need: CNT_W'(1)};
    case (code)
      4'd1:  c = '{1'b1, 3'd0, 4'd2};
      4'd2:  c = '{1'b1, 3'd0, 4'd4};
      4'd3:  c = '{1'b1, 3'd0, 4'd8};
      4'd4:  c = '{1'b0, 3'd1, 4'd6};
      4'd5:  c = '{1'b0, 3'd1, 4'd8};
      4'd6:  c = '{1'b0, 3'd2, 4'd6};
      4'd7:  c = '{1'b0, 3'd2, 4'd8};
      4'd8:  c = '{1'b0, 3'd3, 4'd6};
      4'd9:  c = '{1'b0, 3'd3, 4'd8};
      4'd10: c = '{1'b0, 3'd4, 4'd5};
      4'd11: c = '{1'b0, 3'd4, 4'd6};
      4'd12: c = '{1'b0, 3'd4, 4'd8};
      4'd13: c = '{1'b0, 3'd5, 4'd5};
      4'd14: c = '{1'b0, 3'd5, 4'd6};
      4'd15: c = '{1'b0, 3'd5, 4'd8};
      default: c = '{1'b0, 3'd0, 4'd1};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cgf_sync.sv
module cgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/cgf_tick_gen.sv
module cgf_tick_gen #(
  parameter int DIV_W  = 5,
  parameter int DIVL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_en,
  input  logic              on_clk,
  input  logic [DIVL_W-1:0] div_log2,
  output logic              tick
);
  localparam int WIDE = DIV_W + 1;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] last;
  logic             wrap;

  assign last = DIV_W'((WIDE'(1) << div_log2) - WIDE'(1));
  assign wrap = smp_en && (div_cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_cnt <= '0;
    else if (clr)    div_cnt <= '0;
    else if (wrap)   div_cnt <= '0;
    else if (smp_en) div_cnt <= div_cnt + DIV_W'(1);
  end

  assign tick = !clr && (on_clk || wrap);
endmodule

// File: rtl/cgf_event_cnt.sv
module cgf_event_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             lvl,
  input  logic [CNT_W-1:0] need,
  output logic [CNT_W-1:0] cnt,
  output logic             out
);
  logic [CNT_W-1:0] nxt;
  assign nxt = cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      out <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (lvl == out) begin
        cnt <= '0;
      end else if (nxt >= need) begin
        cnt <= '0;
        out <= lvl;
      end else begin
        cnt <= nxt;
      end
    end
  end
endmodule

// File: rtl/capture_glitch_filter.sv
module capture_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       raw_in,
  input  logic [3:0] flt_code,
  output logic       flt_out
);
  import cgf_pkg::*;

  cfg_t             cfg;
  logic [3:0]       code_q;
  logic             code_chg;
  logic             sync_lvl;
  logic             tick;
  logic [CNT_W-1:0] evt_cnt;

  assign cfg      = decode(flt_code);
  assign code_chg = (flt_code != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= flt_code;
  end

  cgf_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_lvl)
  );

  cgf_tick_gen #(.DIV_W(DIV_W), .DIVL_W(DIVL_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .clr(code_chg), .smp_en(smp_en),
    .on_clk(cfg.on_clk), .div_log2(cfg.div_log2), .tick(tick)
  );

  cgf_event_cnt #(.CNT_W(CNT_W)) evt_i (
    .clk(clk), .rst_n(rst_n), .clr(code_chg), .tick(tick),
    .lvl(sync_lvl), .need(cfg.need), .cnt(evt_cnt), .out(flt_out)
  );
endmodule

// File: rtl/cgf_checker.sv
module cgf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_en,
  input logic [3:0] flt_code,
  input logic       flt_out,
  input logic       sync_lvl,
  input logic [3:0] evt_cnt,
  input logic [3:0] need
);
  assert_code_switch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_code != $past(flt_code)) |=> $stable(flt_out));

  assert_no_enable_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_code >= 4'd4 && !smp_en) |=> $stable(flt_out));

  assert_code0_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_code == 4'd0 && !smp_en) |=> $stable(flt_out));

  assert_change_takes_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_out != $past(flt_out)) |-> (flt_out == $past(sync_lvl)));

  assert_count_below_need_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cnt < need);
endmodule

bind capture_glitch_filter cgf_checker chk_i (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .flt_code(flt_code),
  .flt_out(flt_out), .sync_lvl(sync_lvl), .evt_cnt(evt_cnt), .need(cfg.need)
);

// File: tb/capture_glitch_filter_tb.sv
module capture_glitch_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic raw_in = 1'b0;
  logic [3:0] flt_code = 4'd0;
  logic flt_out;
  int n_run = 0, n_fail = 0;
  int smp_per = 1;
  int ph = 0;
  bit done = 0;

  always #4 clk = ~clk;

  capture_glitch_filter dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .raw_in(raw_in),
    .flt_code(flt_code), .flt_out(flt_out)
  );

  always @(negedge clk) begin
    if (smp_per == 0) smp_en <= 1'b0;
    else if (smp_per == 1) smp_en <= 1'b1;
    else begin
      ph = (ph + 1) % smp_per;
      smp_en <= (ph == 0);
    end
  end

  function automatic int div_of(input int c);
    if (c < 4) return 1;
    if (c < 10) return 1 << (((c - 4) / 2) + 1);
    if (c < 13) return 16;
    return 32;
  endfunction

  function automatic int need_of(input int c);
    if (c == 0) return 1;
    if (c < 4) return 1 << c;
    if (c < 10) return ((c % 2) == 0) ? 6 : 8;
    case ((c - 10) % 3)
      0: return 5;
      1: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp_lo, input int exp_hi);
    n_run++;
    if (act < exp_lo || act > exp_hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic set_code(input int c);
    @(negedge clk);
    flt_code = 4'(c);
    repeat (4) @(negedge clk);
  endtask

  // toggle raw at a negedge, count rising edges until the output follows
  task automatic measure(output int lat);
    @(negedge clk);
    raw_in = ~flt_out;
    lat = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      lat++;
      if (flt_out == raw_in) break;
    end
  endtask

  task automatic quiet(input int cycles, input logic lvl, output int moved);
    moved = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (flt_out != lvl) moved = 1;
    end
  endtask

  initial begin
    int lat, mv, d, n;
    logic held;
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(flt_out), 0, 0);
    rst_n = 1'b1;

    // R2/R3 exact latency, then full table sweep R4/R5/R6
    for (int c = 0; c < 16; c++) begin
      set_code(c);
      d = div_of(c); n = need_of(c);
      measure(lat);
      if (c == 0) check("R2 code0 latency", lat, 3, 3);
      else if (c < 4) check("R4 clock-rate latency", lat, n + 2, n + 2);
      else check("R5 divided latency", lat, 3 + (n - 1) * d, 2 + n * d);
    end

    // R6 pulses covering fewer than N samples are rejected
    for (int c = 1; c < 16; c++) begin
      set_code(c);
      d = div_of(c); n = need_of(c);
      repeat (n * d + 4) @(negedge clk);
      held = flt_out;
      raw_in = ~held;
      repeat ((n - 2) * d > 0 ? (n - 2) * d : 1) @(negedge clk);
      raw_in = held;
      quiet(n * d + 6, held, mv);
      check("R6 short pulse rejected", mv, 0, 0);
    end

    // R3 code 0 with enable low holds, then follows when the enable returns
    set_code(0);
    smp_per = 0;
    @(negedge clk);
    held = flt_out;
    raw_in = ~held;
    quiet(20, held, mv);
    check("R3 code0 enable low holds", mv, 0, 0);
    smp_per = 1;
    repeat (3) @(negedge clk);
    check("R3 code0 follows enable", int'(flt_out == raw_in), 1, 1);

    // R4 clock-rate codes ignore the enable
    set_code(2);
    smp_per = 0;
    measure(lat);
    check("R4 enable ignored", lat, 6, 6);

    // R9 divided code frozen without enable
    set_code(5);
    @(negedge clk);
    held = flt_out;
    raw_in = ~held;
    quiet(300, held, mv);
    check("R9 frozen without enable", mv, 0, 0);
    raw_in = held;
    smp_per = 1;
    repeat (40) @(negedge clk);

    // R5 enable every 3rd cycle, code 4 (D=2, N=6)
    smp_per = 3;
    set_code(4);
    measure(lat);
    check("R5 sparse enable latency", lat, 30, 42);
    smp_per = 1;

    // R7 interrupted run restarts the count
    set_code(3);
    held = flt_out;
    @(negedge clk);
    raw_in = ~held;
    repeat (5) @(negedge clk);
    raw_in = held;
    quiet(3, held, mv);
    check("R7 interrupted run no change", mv, 0, 0);
    repeat (3) @(negedge clk);
    measure(lat);
    check("R7 full restart latency", lat, 10, 10);

    // R8 code switch clears count and holds output
    set_code(3);
    held = flt_out;
    @(negedge clk);
    raw_in = ~held;
    repeat (5) @(negedge clk);
    flt_code = 4'd2;
    lat = 0;
    mv = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lat++;
      if (flt_out != held) break;
    end
    check("R8 count cleared on switch", lat, 5, 5);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule